// File: doc/BRIEF.md
# PLL Divider Selection Controller

This block is the digital control side of a programmable clock generator. Software writes byte registers through a plain address, data and strobe port. These registers hold two divider pairs, a control byte and a software ratio code. The block also holds a copy of the board's five-bit frequency strap code, taken once after reset. From this state it drives the feedback divider (N) and reference divider (M) values for a downstream PLL. It also drives a flag that tells the PLL to use its built-in strap table instead of N/M, the table code for that case, and the ratio code for the derived clocks.

The divider outputs are held registers. They change only on defined trigger events, and each change comes with a one-cycle load strobe. When the external watchdog time-out fires, the block enters a sticky recovery state. In that state the divider comes either from the recovery N/M pair or from the strap table, as a register bit chooses. The block leaves recovery only when software writes a clear bit. A word or block write shows up as back-to-back strobes, so each strobe is handled as a byte write of its own.

Register map (byte address : content):
- 0: recovery N.
- 1: bit 7 recovery source, bits 6:0 recovery M.
- 2: programmed N.
- 3: bits 6:0 programmed M. Writing this address is the program trigger.
- 4: control. Bit 0 is program enable, bit 1 is ratio override, bit 2 is the write-only recovery clear.
- 5: bits 4:0 software ratio code.
- 6: bits 4:0 latched strap code, read-only.
- 7: reserved.

Top module: `pll_div_ctrl`

## Requirements
- R1: During reset every register reads 0, `use_table` is 1, `div_n`/`div_m` are 0 and `load_pulse` is 0. The strap input is captured on the first clock edge after reset is released. Address 6 returns the captured code, and later strap changes do not alter it.
- R2: Registers read back at the addresses above, with unused bits reading 0. Control bit 2 always reads 0. Writes to addresses 6 and 7 are ignored.
- R3: A write to address 3 outside recovery raises `load_pulse` for exactly one cycle, in the second clock cycle after the write strobe edge. At that point the outputs take the current selection. A write to address 2 raises no pulse.
- R4: The selection priority is recovery, then program enable (programmed N/M), then table mode. Table mode means `use_table`=1 with `div_n`=`div_m`=0.
- R5: `wd_timeout` high at a clock edge sets `in_recovery` at that edge, and the next edge gives one load pulse. With recovery source 1 the outputs become recovery N/M. With source 0 they become table mode.
- R6: While in recovery, every write to address 0 or 1 gives a load pulse and applies the recovery values. A write to address 3 gives no pulse and changes no output.
- R7: Writing control bit 2 as 1 while in recovery, with no time-out in the same cycle, clears `in_recovery` and gives one load pulse that applies the normal selection. A time-out in the same cycle keeps recovery and gives no pulse.
- R8: `ratio_code` equals the software code (address 5) when control bit 1 is set, and the latched strap code otherwise. It follows a register write after one clock edge, with no trigger needed.
- R9: `table_code` equals the latched strap code while `use_table` is 1, and 0 otherwise.
- R10: Changes to program enable or to the recovery source bit alone raise no pulse and leave `div_n`, `div_m` and `use_table` unchanged. Between pulses these outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_code | input | 5 | Board frequency strap code |
| wd_timeout | input | 1 | Watchdog time-out event |
| wr_en | input | 1 | Byte write strobe |
| addr | input | 3 | Register address for write and read |
| wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr` |
| div_n | output | 8 | Active feedback divider value |
| div_m | output | 7 | Active reference divider value |
| use_table | output | 1 | PLL uses its strap table instead of N/M |
| table_code | output | 5 | Strap code for table mode |
| ratio_code | output | 5 | Ratio code for derived clocks |
| in_recovery | output | 1 | Recovery state is in force |
| load_pulse | output | 1 | One-cycle strobe to apply new divider values |

## Verification
The bench targets the trigger rules. An N-only write, an enable change or a source change must not pulse. A design that loaded on every write would pulse on each of them. It also writes the programmed M register during recovery, which a design with the wrong priority would let through to the outputs. The bench issues a time-out in the same cycle as a clear write to show that recovery wins and that no stray pulse appears. It changes the strap input after capture, which catches a design that tracks the pin. Recovery is entered with both source settings, so a swapped source decode shows as wrong N/M or a wrong table flag.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
  localparam int N_W    = 8;
  localparam int M_W    = 7;
  localparam int CODE_W = 5;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] A_RCV_N = 3'd0;
  localparam logic [ADDR_W-1:0] A_RCV_M = 3'd1;
  localparam logic [ADDR_W-1:0] A_PRG_N = 3'd2;
  localparam logic [ADDR_W-1:0] A_PRG_M = 3'd3;
  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd4;
  localparam logic [ADDR_W-1:0] A_SEL   = 3'd5;
  localparam logic [ADDR_W-1:0] A_STRAP = 3'd6;

  localparam int B_PEN  = 0;
  localparam int B_OVR  = 1;
  localparam int B_CLR  = 2;
  localparam int B_RSRC = DATA_W - 1;

  typedef struct packed {
    logic           tbl;
    logic [N_W-1:0] n;
    logic [M_W-1:0] m;
  } div_set_t;

  // Priority: recovery, then program enable, then strap table.
  function automatic div_set_t pick_setting(
    input logic           rcv,
    input logic           rsrc,
    input logic           pen,
    input logic [N_W-1:0] rn,
    input logic [M_W-1:0] rm,
    input logic [N_W-1:0] pn,
    input logic [M_W-1:0] pm
  );
    div_set_t s;
    s = '{tbl: 1'b1, n: '0, m: '0};
    if (rcv) begin
      if (rsrc) s = '{tbl: 1'b0, n: rn, m: rm};
    end else if (pen) begin
      s = '{tbl: 1'b0, n: pn, m: pm};
    end
    return s;
  endfunction

  function automatic logic [CODE_W-1:0] pick_ratio(
    input logic              ovr,
    input logic [CODE_W-1:0] sel,
    input logic [CODE_W-1:0] strap
  );
    return ovr ? sel : strap;
  endfunction
endpackage

// File: rtl/pdc_regs.sv
module pdc_regs
  import pdc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CODE_W-1:0] strap_in,
  output logic [DATA_W-1:0] rd_data,
  output logic [N_W-1:0]    rcv_n,
  output logic [M_W-1:0]    rcv_m,
  output logic              rsrc,
  output logic [N_W-1:0]    prg_n,
  output logic [M_W-1:0]    prg_m,
  output logic              pen,
  output logic              ovr,
  output logic [CODE_W-1:0] sel,
  output logic [CODE_W-1:0] strap_q,
  output logic              hit_rcv,
  output logic              hit_prg_m,
  output logic              clr_req
);
  logic strap_done;
  logic wr_rn, wr_rm, wr_pn, wr_pm, wr_ctl, wr_sel;

  assign wr_rn  = wr_en && (addr == A_RCV_N);
  assign wr_rm  = wr_en && (addr == A_RCV_M);
  assign wr_pn  = wr_en && (addr == A_PRG_N);
  assign wr_pm  = wr_en && (addr == A_PRG_M);
  assign wr_ctl = wr_en && (addr == A_CTRL);
  assign wr_sel = wr_en && (addr == A_SEL);

  assign hit_rcv   = wr_rn || wr_rm;
  assign hit_prg_m = wr_pm;
  assign clr_req   = wr_ctl && wdata[B_CLR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcv_n      <= '0;
      rcv_m      <= '0;
      rsrc       <= 1'b0;
      prg_n      <= '0;
      prg_m      <= '0;
      pen        <= 1'b0;
      ovr        <= 1'b0;
      sel        <= '0;
      strap_q    <= '0;
      strap_done <= 1'b0;
    end else begin
      if (!strap_done) begin
        strap_q    <= strap_in;
        strap_done <= 1'b1;
      end
      if (wr_rn) rcv_n <= wdata[N_W-1:0];
      if (wr_rm) begin
        rcv_m <= wdata[M_W-1:0];
        rsrc  <= wdata[B_RSRC];
      end
      if (wr_pn) prg_n <= wdata[N_W-1:0];
      if (wr_pm) prg_m <= wdata[M_W-1:0];
      if (wr_ctl) begin
        pen <= wdata[B_PEN];
        ovr <= wdata[B_OVR];
      end
      if (wr_sel) sel <= wdata[CODE_W-1:0];
    end
  end

  always_comb begin
    rd_data = '0;
    case (addr)
      A_RCV_N: rd_data[N_W-1:0] = rcv_n;
      A_RCV_M: begin
        rd_data[M_W-1:0] = rcv_m;
        rd_data[B_RSRC]  = rsrc;
      end
      A_PRG_N: rd_data[N_W-1:0] = prg_n;
      A_PRG_M: rd_data[M_W-1:0] = prg_m;
      A_CTRL: begin
        rd_data[B_PEN] = pen;
        rd_data[B_OVR] = ovr;
      end
      A_SEL:   rd_data[CODE_W-1:0] = sel;
      A_STRAP: rd_data[CODE_W-1:0] = strap_q;
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/pdc_recov.sv
module pdc_recov (
  input  logic clk,
  input  logic rst_n,
  input  logic wd_timeout,
  input  logic clr_req,
  input  logic hit_rcv,
  input  logic hit_prg_m,
  output logic rcv_active,
  output logic load_req
);
  logic rcv_nxt;
  logic enter_ev, leave_ev, rcv_wr_ev, prg_ev;

  assign rcv_nxt   = wd_timeout || (rcv_active && !clr_req);
  assign enter_ev  = wd_timeout && !rcv_active;
  assign leave_ev  = rcv_active && clr_req && !wd_timeout;
  assign rcv_wr_ev = rcv_active && hit_rcv;
  assign prg_ev    = hit_prg_m && !rcv_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcv_active <= 1'b0;
      load_req   <= 1'b0;
    end else begin
      rcv_active <= rcv_nxt;
      load_req   <= enter_ev || leave_ev || rcv_wr_ev || prg_ev;
    end
  end
endmodule

// File: rtl/pdc_active.sv
module pdc_active
  import pdc_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_req,
  input  div_set_t       setting,
  output logic [N_W-1:0] div_n,
  output logic [M_W-1:0] div_m,
  output logic           use_table,
  output logic           load_pulse
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_n      <= '0;
      div_m      <= '0;
      use_table  <= 1'b1;
      load_pulse <= 1'b0;
    end else begin
      load_pulse <= load_req;
      if (load_req) begin
        div_n     <= setting.n;
        div_m     <= setting.m;
        use_table <= setting.tbl;
      end
    end
  end
endmodule

// File: rtl/pll_div_ctrl.sv
module pll_div_ctrl
  import pdc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] strap_code,
  input  logic              wd_timeout,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic [N_W-1:0]    div_n,
  output logic [M_W-1:0]    div_m,
  output logic              use_table,
  output logic [CODE_W-1:0] table_code,
  output logic [CODE_W-1:0] ratio_code,
  output logic              in_recovery,
  output logic              load_pulse
);
  logic [N_W-1:0]    rcv_n, prg_n;
  logic [M_W-1:0]    rcv_m, prg_m;
  logic              rsrc, pen, ovr;
  logic [CODE_W-1:0] sel, strap_q;
  logic              hit_rcv, hit_prg_m, clr_req;
  logic              load_req;
  div_set_t          setting;

  pdc_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .strap_in(strap_code), .rd_data(rd_data),
    .rcv_n(rcv_n), .rcv_m(rcv_m), .rsrc(rsrc),
    .prg_n(prg_n), .prg_m(prg_m), .pen(pen), .ovr(ovr),
    .sel(sel), .strap_q(strap_q),
    .hit_rcv(hit_rcv), .hit_prg_m(hit_prg_m), .clr_req(clr_req)
  );

  pdc_recov u_recov (
    .clk(clk), .rst_n(rst_n), .wd_timeout(wd_timeout), .clr_req(clr_req),
    .hit_rcv(hit_rcv), .hit_prg_m(hit_prg_m),
    .rcv_active(in_recovery), .load_req(load_req)
  );

  assign setting = pick_setting(in_recovery, rsrc, pen, rcv_n, rcv_m, prg_n, prg_m);

  pdc_active u_active (
    .clk(clk), .rst_n(rst_n), .load_req(load_req), .setting(setting),
    .div_n(div_n), .div_m(div_m), .use_table(use_table), .load_pulse(load_pulse)
  );

  assign table_code = use_table ? strap_q : '0;
  assign ratio_code = pick_ratio(ovr, sel, strap_q);
endmodule

// File: rtl/pll_div_ctrl_chk.sv
module pll_div_ctrl_chk
  import pdc_pkg::*;
(
  input logic           clk,
  input logic           rst_n,
  input logic           wd_timeout,
  input logic           load_req,
  input logic           load_pulse,
  input logic           in_recovery,
  input logic [N_W-1:0] div_n,
  input logic [M_W-1:0] div_m,
  input logic           use_table
);
  p_pulse_after_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load_req |=> load_pulse);
  p_no_stray_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !load_req |=> !load_pulse);
  p_hold_between_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !load_pulse |-> ($stable(div_n) && $stable(div_m) && $stable(use_table)));
  p_table_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    use_table |-> (div_n == '0 && div_m == '0));
  p_wd_enters_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wd_timeout |=> in_recovery);
  p_enter_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_recovery) |=> load_pulse);
  p_leave_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_recovery) |=> load_pulse);
endmodule

bind pll_div_ctrl pll_div_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wd_timeout(wd_timeout), .load_req(load_req),
  .load_pulse(load_pulse), .in_recovery(in_recovery), .div_n(div_n),
  .div_m(div_m), .use_table(use_table)
);

// File: tb/pll_div_ctrl_tb.sv
module pll_div_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] strap_code = 5'h13;
  logic       wd_timeout = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rd_data;
  logic [7:0] div_n;
  logic [6:0] div_m;
  logic       use_table;
  logic [4:0] table_code, ratio_code;
  logic       in_recovery, load_pulse;

  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  pll_div_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .strap_code(strap_code), .wd_timeout(wd_timeout),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rd_data(rd_data),
    .div_n(div_n), .div_m(div_m), .use_table(use_table), .table_code(table_code),
    .ratio_code(ratio_code), .in_recovery(in_recovery), .load_pulse(load_pulse)
  );

  // {addr, write data, expected readback}  (R2)
  localparam logic [18:0] VEC [8] = '{
    {3'd0, 8'hA5, 8'hA5},
    {3'd1, 8'hFF, 8'hFF},
    {3'd2, 8'h3C, 8'h3C},
    {3'd3, 8'hFF, 8'h7F},
    {3'd4, 8'hFF, 8'h03},
    {3'd5, 8'hFF, 8'h1F},
    {3'd6, 8'h00, 8'h13},
    {3'd7, 8'hFF, 8'h00}
  };

  task automatic chk(input string tag, input int act, input int exp_v);
    n_run++;
    if (act != exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp_v);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    addr = a;
    #1;
    v = rd_data;
  endtask

  // Called right after a trigger: pulse appears one negedge later, for one cycle.
  task automatic expect_load(input string tag, input int n, input int m, input int tbl);
    chk({tag, " pulse early"}, int'(load_pulse), 0);
    @(negedge clk);
    chk({tag, " pulse"}, int'(load_pulse), 1);
    chk({tag, " div_n"}, int'(div_n), n);
    chk({tag, " div_m"}, int'(div_m), m);
    chk({tag, " use_table"}, int'(use_table), tbl);
    @(negedge clk);
    chk({tag, " pulse width"}, int'(load_pulse), 0);
  endtask

  task automatic expect_none(input string tag, input int n, input int m, input int tbl);
    for (int k = 0; k < 2; k++) begin
      chk({tag, " no pulse"}, int'(load_pulse), 0);
      chk({tag, " div_n held"}, int'(div_n), n);
      chk({tag, " div_m held"}, int'(div_m), m);
      chk({tag, " table held"}, int'(use_table), tbl);
      @(negedge clk);
    end
  endtask

  task automatic wd_pulse();
    @(negedge clk);
    wd_timeout = 1'b1;
    @(negedge clk);
    wd_timeout = 1'b0;
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 reset use_table", int'(use_table), 1);
    chk("R1 reset div_n", int'(div_n), 0);
    chk("R1 reset pulse", int'(load_pulse), 0);
    chk("R1 reset recovery", int'(in_recovery), 0);
    rd(3'd6, v); chk("R1 reset strap reg", int'(v), 0);
    rd(3'd1, v); chk("R1 reset reg1", int'(v), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); strap_code = 5'h0A;
    @(negedge clk);
    rd(3'd6, v); chk("R1 strap latched once", int'(v), 'h13);
    chk("R8 ratio from strap", int'(ratio_code), 'h13);
    chk("R9 table_code", int'(table_code), 'h13);

    // R2: table-driven write / readback
    for (int i = 0; i < 8; i++) begin
      wr(VEC[i][18:16], VEC[i][15:8]);
      rd(VEC[i][18:16], v);
      chk("R2 readback", int'(v), int'(VEC[i][7:0]));
    end
    @(negedge clk);

    // R10: enable change alone does nothing; R3: N alone no pulse
    wr(3'd4, 8'h01);
    expect_none("R10 enable only", 0, 0, 1);
    chk("R8 override clear", int'(ratio_code), 'h13);
    wr(3'd2, 8'h40);
    expect_none("R3 N only", 0, 0, 1);
    wr(3'd3, 8'h21);
    expect_load("R3 M trigger", 'h40, 'h21, 0);
    chk("R9 table_code zero", int'(table_code), 0);

    // R8: ratio override
    wr(3'd4, 8'h03);
    chk("R8 override sel", int'(ratio_code), 'h1F);
    wr(3'd5, 8'h05);
    chk("R8 new sel", int'(ratio_code), 'h05);
    wr(3'd4, 8'h01);
    chk("R8 back to strap", int'(ratio_code), 'h13);

    // R5: recovery from recovery pair
    wr(3'd0, 8'h55);
    expect_none("R10 rcv N outside recovery", 'h40, 'h21, 0);
    wr(3'd1, 8'h91);
    expect_none("R10 rsrc outside recovery", 'h40, 'h21, 0);
    wd_pulse();
    chk("R5 enter", int'(in_recovery), 1);
    expect_load("R5 recovery pair", 'h55, 'h11, 0);

    // R6: writes in recovery
    wr(3'd0, 8'h66);
    expect_load("R6 rcv N write", 'h66, 'h11, 0);
    wr(3'd3, 8'h22);
    expect_none("R6 prg M blocked", 'h66, 'h11, 0);

    // R7: clear -> normal (programmed, R4 priority)
    wr(3'd4, 8'h05);
    chk("R7 left recovery", int'(in_recovery), 0);
    expect_load("R7 clear", 'h40, 'h22, 0);

    // R5: recovery from strap table
    wr(3'd1, 8'h11);
    wd_pulse();
    expect_load("R5 table source", 0, 0, 1);
    chk("R9 table code in recovery", int'(table_code), 'h13);

    // R7: time-out with clear in same cycle
    @(negedge clk);
    wd_timeout = 1'b1; wr_en = 1'b1; addr = 3'd4; wdata = 8'h05;
    @(negedge clk);
    wd_timeout = 1'b0; wr_en = 1'b0;
    chk("R7 timeout wins", int'(in_recovery), 1);
    expect_none("R7 no pulse on tie", 0, 0, 1);
    wr(3'd4, 8'h05);
    expect_load("R7 clear later", 'h40, 'h22, 0);

    // R4: enable off -> table mode at next trigger
    wr(3'd4, 8'h00);
    expect_none("R10 disable only", 'h40, 'h22, 0);
    wr(3'd3, 8'h22);
    expect_load("R4 table fallback", 0, 0, 1);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule